// File: doc/BRIEF.md
# MOESI Snooping Coherence Controller

This block keeps the coherence state of every line in a private first-level cache that sits on an atomic snooping bus. A small direct-mapped tag array holds one of five stable states for each line: Modified, Owned, Exclusive, Shared or Invalid. The core presents load, store and eviction requests. The bus presents the Get and Put transactions that other controllers issue. The controller decides three things: whether a local access may complete, which bus transaction it has to issue, and whether it has to supply the data for a remote request.

The bus is atomic, so a Get that this block issues completes in the cycle it is issued. The requesting line is installed in its final state immediately. When a local request and a snoop arrive in the same cycle, the snoop is applied first, and the local request then sees the state the snoop left behind. A compile-time parameter narrows the protocol. It can remove the Owned state to give MESI, or remove both Owned and Exclusive to give MSI. Every response appears on registered outputs one cycle after the request.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid, and respValid, busValid and snoopSupply are low. The first load to any address then issues a bus transaction.
- R2: A load to a line held in M, O, E or S is granted with no bus transaction. The response appears one cycle after the request.
- R3: A load miss issues GetS (busKind 0) and is granted. The line is installed in E when localShared is low, and in S when localShared is high.
- R4: A store to a line in M is granted with no bus transaction. A store to a line in E is granted with no bus transaction and moves the line to M.
- R5: A store to a line in S, O or I issues GetM (busKind 1), is granted, and leaves the line in M.
- R6: A snooped GetS (snoopKind 0) that matches a valid line raises snoopShared. A line in M moves to O and supplies data. A line in O supplies data and stays in O. A line in E moves to S without supplying data.
- R7: A snooped GetM (snoopKind 1) that matches a valid line invalidates it. Data is supplied only when the line was in M or O.
- R8: A snooped Put (snoopKind 2), and any snoop whose tag differs from the one held at that index, changes no state and raises neither snoopSupply nor snoopShared.
- R9: An eviction (localOp 2) of a line in M or O issues Put (busKind 2) with the line address and leaves the line Invalid. An eviction of a line in E or S drops the line silently.
- R10: A load or store whose index holds a valid line with a different tag is not granted. The old line is removed, with a Put to the old address if it was in M or O and silently otherwise. A retry of the request then misses normally.
- R11: When a snoop and a local request target the same line in the same cycle, the local request is decided on the state that results from the snoop.
- R12: In MESI mode a snooped GetS moves M to S with a data supply. In MSI mode a load miss always installs S. Local ops are encoded load=0, store=1, evict=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| localValid | input | 1 | Core request present |
| localOp | input | 2 | 0 load, 1 store, 2 evict |
| localAddr | input | ADDR_W | Line address of the core request |
| localShared | input | 1 | Another cache reported a copy during this cycle's GetS |
| snoopValid | input | 1 | Remote bus transaction present |
| snoopKind | input | 2 | 0 GetS, 1 GetM, 2 Put |
| snoopAddr | input | ADDR_W | Line address of the remote transaction |
| respValid | output | 1 | Response to last cycle's core request |
| respGrant | output | 1 | Core access completed |
| busValid | output | 1 | Transaction issued on the bus |
| busKind | output | 2 | 0 GetS, 1 GetM, 2 Put |
| busAddr | output | ADDR_W | Address of the issued transaction |
| snoopSupply | output | 1 | This cache supplies data for last cycle's snoop |
| snoopShared | output | 1 | This cache holds a copy after last cycle's GetS snoop |

## Verification
A wrong line state never shows at the ports directly. It shows on the next access to that line. For example, a line wrongly left in M answers a store with no GetM. A line wrongly left in S answers a GetS snoop with no data supply. A line that was wrongly dropped answers a load with a GetS. For this reason each scenario follows its stimulus with a probe access, and the error becomes visible on the registered outputs one cycle after that probe. Conflicts at the same index and the ordering of a snoop against a local request in the same cycle are exercised directly, because a fault there corrupts a neighbouring line or the current response.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_O, ST_M} lineState_t;
  typedef enum logic [1:0] {BUS_GETS = 2'd0, BUS_GETM = 2'd1, BUS_PUT = 2'd2} busKind_t;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2} localOp_t;
  typedef enum logic [1:0] {PROTO_MOESI, PROTO_MESI, PROTO_MSI} protocol_t;

  typedef struct packed {
    logic       snoopWr;
    lineState_t snoopNext;
    logic       localWr;
    lineState_t localNext;
    logic       respValid;
    logic       respGrant;
    logic       busValid;
    busKind_t   busKind;
    logic       busVictim;
    logic       supply;
    logic       shared;
  } strobe_t;
endpackage

// File: rtl/moesi_datapath.sv
module moesi_datapath
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_LINES = 16,
  parameter protocol_t PROTO = PROTO_MOESI
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           str,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              localValid,
  input  logic              snoopValid,
  output lineState_t        localRdState,
  output logic [ADDR_W-$clog2(NUM_LINES)-1:0] localRdTag,
  output lineState_t        snoopRdState,
  output logic [ADDR_W-$clog2(NUM_LINES)-1:0] snoopRdTag,
  output logic              respValid,
  output logic              respGrant,
  output logic              busValid,
  output logic [1:0]        busKind,
  output logic [ADDR_W-1:0] busAddr,
  output logic              snoopSupply,
  output logic              snoopShared
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t stateArr [NUM_LINES];
  logic [TAG_W-1:0] tagArr [NUM_LINES];

  logic [IDX_W-1:0] lIdx, sIdx;
  assign lIdx = localAddr[IDX_W-1:0];
  assign sIdx = snoopAddr[IDX_W-1:0];

  assign localRdState = stateArr[lIdx];
  assign localRdTag   = tagArr[lIdx];
  assign snoopRdState = stateArr[sIdx];
  assign snoopRdTag   = tagArr[sIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stateArr[i] <= ST_I;
        tagArr[i]   <= '0;
      end
      respValid   <= 1'b0;
      respGrant   <= 1'b0;
      busValid    <= 1'b0;
      busKind     <= 2'd0;
      busAddr     <= '0;
      snoopSupply <= 1'b0;
      snoopShared <= 1'b0;
    end else begin
      if (str.snoopWr) stateArr[sIdx] <= str.snoopNext;
      if (str.localWr) begin
        stateArr[lIdx] <= str.localNext;
        tagArr[lIdx]   <= localAddr[ADDR_W-1:IDX_W];
      end
      respValid   <= str.respValid;
      respGrant   <= str.respGrant;
      busValid    <= str.busValid;
      busKind     <= str.busKind;
      busAddr     <= str.busVictim ? {localRdTag, lIdx} : localAddr;
      snoopSupply <= str.supply;
      snoopShared <= str.shared;
    end
  end

  // Registered outputs must trace back to a request in the previous cycle.
  assert_bus_from_req_R3: assert property (@(posedge clk) disable iff (rst)
    busValid |-> $past(localValid))
    else $error("bus transaction without a local request");
  assert_supply_from_snoop_R7: assert property (@(posedge clk) disable iff (rst)
    (snoopSupply || snoopShared) |-> $past(snoopValid))
    else $error("snoop response without a snoop");
  assert_grant_in_resp_R2: assert property (@(posedge clk) disable iff (rst)
    respGrant |-> respValid)
    else $error("grant outside a response");
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busValid && !respValid && !snoopSupply))
    else $error("outputs active right after reset");

  if (PROTO == PROTO_MSI) begin : g_noE
    assert_msi_no_e_R12: assert property (@(posedge clk) disable iff (rst)
      !(str.localWr && str.localNext == ST_E) && !(str.snoopWr && str.snoopNext == ST_E))
      else $error("E state written in MSI mode");
  end
  if (PROTO != PROTO_MOESI) begin : g_noO
    assert_no_owned_R12: assert property (@(posedge clk) disable iff (rst)
      !(str.localWr && str.localNext == ST_O) && !(str.snoopWr && str.snoopNext == ST_O))
      else $error("O state written without MOESI");
  end
endmodule

// File: rtl/moesi_control.sv
module moesi_control
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_LINES = 16,
  parameter protocol_t PROTO = PROTO_MOESI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              localValid,
  input  logic [1:0]        localOp,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              localShared,
  input  logic              snoopValid,
  input  logic [1:0]        snoopKind,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  lineState_t        localRdState,
  input  logic [ADDR_W-$clog2(NUM_LINES)-1:0] localRdTag,
  input  lineState_t        snoopRdState,
  input  logic [ADDR_W-$clog2(NUM_LINES)-1:0] snoopRdTag,
  output strobe_t           str
);
  localparam int IDX_W = $clog2(NUM_LINES);

  busKind_t   sKind;
  localOp_t   lOp;
  logic       snoopMatch, tagHit, present, conflict, sameLine;
  lineState_t curState;

  assign sKind = busKind_t'(snoopKind);
  assign lOp   = localOp_t'(localOp);
  assign snoopMatch = snoopValid && snoopRdState != ST_I
                      && snoopRdTag == snoopAddr[ADDR_W-1:IDX_W];
  assign sameLine = snoopAddr == localAddr;

  always_comb begin
    str = '0;
    str.snoopNext = snoopRdState;
    str.localNext = ST_I;
    str.busKind   = BUS_GETS;
    // Snooped transaction: applied first.
    if (snoopMatch) begin
      case (sKind)
        BUS_GETS: begin
          str.shared = 1'b1;
          case (snoopRdState)
            ST_M: begin
              str.supply    = 1'b1;
              str.snoopNext = (PROTO == PROTO_MOESI) ? ST_O : ST_S;
            end
            ST_O: str.supply = 1'b1;
            ST_E: str.snoopNext = ST_S;
            default: ;
          endcase
        end
        BUS_GETM: begin
          str.supply    = (snoopRdState == ST_M) || (snoopRdState == ST_O);
          str.snoopNext = ST_I;
        end
        default: ;
      endcase
      str.snoopWr = (sKind != BUS_PUT);
    end
    // Local request sees the post-snoop state of its line.
    curState = (snoopMatch && sameLine) ? str.snoopNext : localRdState;
    tagHit   = localRdTag == localAddr[ADDR_W-1:IDX_W];
    present  = curState != ST_I && tagHit;
    conflict = curState != ST_I && !tagHit;
    if (localValid) begin
      str.respValid = 1'b1;
      if (conflict && lOp != OP_EVICT) begin
        str.localWr   = 1'b1;
        str.localNext = ST_I;
        str.busVictim = 1'b1;
        str.busKind   = BUS_PUT;
        str.busValid  = (curState == ST_M) || (curState == ST_O);
      end else begin
        str.respGrant = 1'b1;
        case (lOp)
          OP_LOAD: if (!present) begin
            str.busValid  = 1'b1;
            str.busKind   = BUS_GETS;
            str.localWr   = 1'b1;
            str.localNext = (!localShared && PROTO != PROTO_MSI) ? ST_E : ST_S;
          end
          OP_STORE: if (!present || curState != ST_M) begin
            str.localWr   = 1'b1;
            str.localNext = ST_M;
            if (!(present && curState == ST_E)) begin
              str.busValid = 1'b1;
              str.busKind  = BUS_GETM;
            end
          end
          OP_EVICT: if (present) begin
            str.localWr   = 1'b1;
            str.localNext = ST_I;
            str.busKind   = BUS_PUT;
            str.busValid  = (curState == ST_M) || (curState == ST_O);
          end
          default: ;
        endcase
      end
    end
  end

  // A granted store always ends with the line in M.
  assert_store_owns_R4: assert property (@(posedge clk) disable iff (rst)
    (localValid && lOp == OP_STORE && str.respGrant)
      |-> (str.localWr ? str.localNext == ST_M : curState == ST_M))
    else $error("granted store without M");
  // Only an owner (M or O) supplies data.
  assert_owner_supplies_R6: assert property (@(posedge clk) disable iff (rst)
    str.supply |-> (snoopRdState == ST_M || snoopRdState == ST_O))
    else $error("non-owner supplied data");
endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_LINES = 16,
  parameter protocol_t PROTO = PROTO_MOESI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              localValid,
  input  logic [1:0]        localOp,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              localShared,
  input  logic              snoopValid,
  input  logic [1:0]        snoopKind,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              respValid,
  output logic              respGrant,
  output logic              busValid,
  output logic [1:0]        busKind,
  output logic [ADDR_W-1:0] busAddr,
  output logic              snoopSupply,
  output logic              snoopShared
);
  localparam int TAG_W = ADDR_W - $clog2(NUM_LINES);

  strobe_t          str;
  lineState_t       localRdState, snoopRdState;
  logic [TAG_W-1:0] localRdTag, snoopRdTag;

  moesi_control #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .PROTO(PROTO)) u_control (
    .clk(clk), .rst(rst),
    .localValid(localValid), .localOp(localOp), .localAddr(localAddr),
    .localShared(localShared), .snoopValid(snoopValid), .snoopKind(snoopKind),
    .snoopAddr(snoopAddr), .localRdState(localRdState), .localRdTag(localRdTag),
    .snoopRdState(snoopRdState), .snoopRdTag(snoopRdTag), .str(str)
  );

  moesi_datapath #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .PROTO(PROTO)) u_datapath (
    .clk(clk), .rst(rst), .str(str),
    .localAddr(localAddr), .snoopAddr(snoopAddr),
    .localValid(localValid), .snoopValid(snoopValid),
    .localRdState(localRdState), .localRdTag(localRdTag),
    .snoopRdState(snoopRdState), .snoopRdTag(snoopRdTag),
    .respValid(respValid), .respGrant(respGrant),
    .busValid(busValid), .busKind(busKind), .busAddr(busAddr),
    .snoopSupply(snoopSupply), .snoopShared(snoopShared)
  );
endmodule

// File: tb/moesi_ctrl_bench.sv
module moesi_ctrl_bench;
  import moesi_pkg::*;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          localValid = 0, localShared = 0, snoopValid = 0;
  logic [1:0]    localOp = 0, snoopKind = 0;
  logic [AW-1:0] localAddr = 0, snoopAddr = 0;

  logic rv[3], rg[3], bv[3], sup[3], shr[3];
  logic [1:0] bk[3];
  logic [AW-1:0] ba[3];

  moesi_ctrl #(.PROTO(PROTO_MOESI)) u_moesi_ctrl (
    .clk(clk), .rst(rst), .localValid(localValid), .localOp(localOp),
    .localAddr(localAddr), .localShared(localShared), .snoopValid(snoopValid),
    .snoopKind(snoopKind), .snoopAddr(snoopAddr), .respValid(rv[0]), .respGrant(rg[0]),
    .busValid(bv[0]), .busKind(bk[0]), .busAddr(ba[0]), .snoopSupply(sup[0]),
    .snoopShared(shr[0]));
  moesi_ctrl #(.PROTO(PROTO_MESI)) u_mesi (
    .clk(clk), .rst(rst), .localValid(localValid), .localOp(localOp),
    .localAddr(localAddr), .localShared(localShared), .snoopValid(snoopValid),
    .snoopKind(snoopKind), .snoopAddr(snoopAddr), .respValid(rv[1]), .respGrant(rg[1]),
    .busValid(bv[1]), .busKind(bk[1]), .busAddr(ba[1]), .snoopSupply(sup[1]),
    .snoopShared(shr[1]));
  moesi_ctrl #(.PROTO(PROTO_MSI)) u_msi (
    .clk(clk), .rst(rst), .localValid(localValid), .localOp(localOp),
    .localAddr(localAddr), .localShared(localShared), .snoopValid(snoopValid),
    .snoopKind(snoopKind), .snoopAddr(snoopAddr), .respValid(rv[2]), .respGrant(rg[2]),
    .busValid(bv[2]), .busKind(bk[2]), .busAddr(ba[2]), .snoopSupply(sup[2]),
    .snoopShared(shr[2]));

  int nChecks = 0, nFails = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: optional local op and optional snoop, sampled after the edge.
  task automatic step(input bit lv, input int op, input int la, input bit sh,
                      input bit sv, input int sk, input int sa);
    @(negedge clk);
    localValid = lv; localOp = op[1:0]; localAddr = la[AW-1:0]; localShared = sh;
    snoopValid = sv; snoopKind = sk[1:0]; snoopAddr = sa[AW-1:0];
    @(posedge clk); #1;
    localValid = 0; snoopValid = 0;
  endtask

  task automatic ld(input int a, input bit sh = 0); step(1, 0, a, sh, 0, 0, 0); endtask
  task automatic stv(input int a); step(1, 1, a, 0, 0, 0, 0); endtask
  task automatic ev(input int a); step(1, 2, a, 0, 0, 0, 0); endtask
  task automatic sn(input int k, input int a); step(0, 0, 0, 0, 1, k, a); endtask

  task automatic t_reset();
    check("R1 respValid", rv[0], 0);
    check("R1 busValid", bv[0], 0);
    check("R1 supply", sup[0], 0);
    ld('h010);
    check("R1 first load issues bus", bv[0], 1);
  endtask

  task automatic t_loadMiss();
    ld('h101, 0);
    check("R3 GetS valid", bv[0], 1);
    check("R3 GetS kind", bk[0], 0);
    check("R3 grant", rg[0], 1);
    stv('h101);
    check("R4 store in E no bus", bv[0], 0);
    check("R4 store in E grant", rg[0], 1);
    ld('h102, 1);
    check("R3 shared miss GetS", bk[0], 0);
    stv('h102);
    check("R5 store in S GetM valid", bv[0], 1);
    check("R5 store in S GetM kind", bk[0], 1);
    check("R5 store grant", rg[0], 1);
  endtask

  task automatic t_loadHit();
    ld('h101);
    check("R2 load hit grant", rg[0], 1);
    check("R2 load hit no bus", bv[0], 0);
    stv('h101);
    check("R4 store in M no bus", bv[0], 0);
  endtask

  task automatic t_snoopGetS();
    sn(0, 'h101);
    check("R6 M supplies", sup[0], 1);
    check("R6 shared", shr[0], 1);
    sn(0, 'h101);
    check("R6 O supplies again", sup[0], 1);
    ld('h101);
    check("R2 load hit in O", bv[0], 0);
    stv('h101);
    check("R5 store in O GetM", bk[0], 1);
    check("R5 store in O bus", bv[0], 1);
    ld('h103, 0);
    sn(0, 'h103);
    check("R6 E no supply", sup[0], 0);
    check("R6 E shared", shr[0], 1);
    stv('h103);
    check("R6 E became S: GetM", bv[0], 1);
  endtask

  task automatic t_snoopGetM();
    sn(1, 'h101);
    check("R7 M supplies on GetM", sup[0], 1);
    ld('h101);
    check("R7 M invalidated", bv[0], 1);
    ld('h104, 0);
    sn(1, 'h104);
    check("R7 E no supply", sup[0], 0);
    check("R7 no shared on GetM", shr[0], 0);
    ld('h104);
    check("R7 E invalidated", bv[0], 1);
  endtask

  task automatic t_ignore();
    ld('h105, 0);
    sn(2, 'h105);
    check("R8 Put no supply", sup[0], 0);
    check("R8 Put no shared", shr[0], 0);
    sn(1, 'h205);
    check("R8 other tag no supply", sup[0], 0);
    sn(0, 'h205);
    check("R8 other tag no shared", shr[0], 0);
    stv('h105);
    check("R8 line still E", bv[0], 0);
  endtask

  task automatic t_evict();
    stv('h106);
    ev('h106);
    check("R9 M evict Put", bk[0], 2);
    check("R9 M evict valid", bv[0], 1);
    check("R9 M evict addr", ba[0], 'h106);
    ld('h106, 0);
    check("R9 M evict left I", bv[0], 1);
    ev('h106);
    check("R9 E evict silent", bv[0], 0);
    ld('h106);
    check("R9 E evict left I", bv[0], 1);
    stv('h107);
    sn(0, 'h107);
    ev('h107);
    check("R9 O evict Put", bv[0], 1);
    check("R9 O evict kind", bk[0], 2);
  endtask

  task automatic t_conflict();
    stv('h010);
    ld('h020);
    check("R10 conflict no grant", rg[0], 0);
    check("R10 victim Put", bv[0], 1);
    check("R10 victim kind", bk[0], 2);
    check("R10 victim addr", ba[0], 'h010);
    ld('h020, 0);
    check("R10 retry GetS", bk[0], 0);
    check("R10 retry grant", rg[0], 1);
    ld('h010);
    check("R10 clean victim no grant", rg[0], 0);
    check("R10 clean victim silent", bv[0], 0);
  endtask

  task automatic t_same();
    ld('h108, 0);
    step(1, 1, 'h108, 0, 1, 0, 'h108);
    check("R11 snoop first: store GetM", bk[0], 1);
    check("R11 snoop first: bus", bv[0], 1);
    check("R11 E snooped no supply", sup[0], 0);
    check("R11 shared", shr[0], 1);
    stv('h108);
    check("R11 now M", bv[0], 0);
  endtask

  task automatic t_variants();
    stv('h109);
    sn(0, 'h109);
    check("R12 MESI M supplies", sup[1], 1);
    sn(0, 'h109);
    check("R12 MESI went S not O", sup[1], 0);
    check("R12 MOESI O supplies", sup[0], 1);
    ld('h10A, 0);
    stv('h10A);
    check("R12 MSI installs S", bv[2], 1);
    check("R12 MOESI installs E", bv[0], 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        t_reset();
        t_loadMiss();
        t_loadHit();
        t_snoopGetS();
        t_snoopGetM();
        t_ignore();
        t_evict();
        t_conflict();
        t_same();
        t_variants();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule